// File: doc/BRIEF.md
# DDR2 Write-Turnaround Command Gate

This block sits between a memory controller's command arbiter and the DRAM command bus. Each cycle the arbiter offers one command with a bank number. The gate answers combinationally with a ready signal. A command counts as issued in a cycle where valid and ready are both high. After an issued WRITE, the gate holds back a READ to any bank until the write-to-read turnaround has passed. It holds back a PRECHARGE to the written bank until the write burst has finished and write recovery has elapsed. It also holds back an ACTIVATE to a bank until the row-precharge time after that bank's PRECHARGE has passed.

All spacings come from static configuration inputs. These are additive latency, CAS latency, a burst-length select, and the three recovery times in clocks. The gate does not use fixed delay constants. Read latency is AL + CL and write latency is one clock less. Whenever a valid request is held, a reason code says which timing rule is blocking it. A held command is never dropped: the arbiter keeps it on the request lines until ready rises.

Top module: `twg_gate`

## Requirements
- R1: After reset no spacing is pending: a READ, PRECHARGE or ACTIVATE to any bank is ready at once, with reason code 0.
- R2: With a WRITE issued in cycle t, a READ to any bank is first ready in cycle t + (CL - 1) + BL/2 + tWTR.
- R3: A READ offered in the cycle before that earliest cycle is held with ready low and reason code 1 (turnaround).
- R4: With a WRITE issued in cycle t, a PRECHARGE to the same bank is first ready in cycle t + WL + BL/2 + tWR, where WL = AL + CL - 1. In the cycle before that, it is held with reason code 2 (recovery).
- R5: A PRECHARGE to a bank other than the written one is ready in the cycle right after the WRITE.
- R6: With a PRECHARGE issued to bank b in cycle t, an ACTIVATE to bank b is first ready in cycle t + tRP. In the cycle before that, it is held with reason code 3. An ACTIVATE to another bank is not held.
- R7: Command codes are 0 NOP, 1 ACTIVATE, 2 WRITE, 3 READ, 4 PRECHARGE. NOP and WRITE are always ready, including in the cycle right after a WRITE.
- R8: The burst-length select picks BL/2 = 2 when low (four-beat bursts) and BL/2 = 4 when high (eight-beat bursts). This value enters both the R2 and the R4 spacing.
- R9: A second WRITE restarts the turnaround spacing, so the earliest READ is measured from the later WRITE.
- R10: The reason code is 0 whenever ready is high or valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_al | input | 3 | Additive latency in clocks |
| cfg_cl | input | 3 | CAS latency in clocks |
| cfg_bl8 | input | 1 | Burst-length select: 0 gives BL/2 = 2, 1 gives BL/2 = 4 |
| cfg_twtr | input | 4 | Write-to-read internal transfer time in clocks |
| cfg_twr | input | 4 | Write recovery time in clocks |
| cfg_trp | input | 4 | Row precharge time in clocks |
| req_valid | input | 1 | Command offered this cycle |
| req_cmd | input | 3 | Command code (see R7) |
| req_bank | input | 2 | Target bank |
| req_ready | output | 1 | Command may issue this cycle |
| hold_why | output | 2 | Reason for a held request: 0 none, 1 turnaround, 2 recovery, 3 precharge |

## Verification
The bench sweeps additive latency, CAS latency, both burst lengths, and two values each of tWTR and tWR. For every point it measures the exact cycle in which a READ and a same-bank PRECHARGE first become ready. A gate with an off-by-one counter load, or one that mixes up read and write latency, would release a cycle early or late, and the one-cycle-early probe or the measured gap would catch it. A gate with a single shared recovery counter, or with the wrong BL/2 selection, would stall a PRECHARGE to an untouched bank, or would give the wrong gap only for eight-beat bursts. A gate that failed to reload on a second WRITE would let a READ through too soon after back-to-back writes.

// File: rtl/twg_pkg.sv
package twg_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_WR  = 3'd2,
      CMD_RD  = 3'd3,
      CMD_PRE = 3'd4
   } twg_cmd_e;

   typedef enum logic [1:0] {
      HOLD_NONE = 2'd0,
      HOLD_WTR  = 2'd1,
      HOLD_WR   = 2'd2,
      HOLD_RP   = 2'd3
   } twg_hold_e;

endpackage

// File: rtl/twg_lat_calc.sv
// Derives command spacings (in clocks) from the static timing configuration.
module twg_lat_calc #(
   parameter int LAT_W = 3,
   parameter int T_W   = 4,
   parameter int CNT_W = 8
) (
   input  logic [LAT_W-1:0] al,
   input  logic [LAT_W-1:0] cl,
   input  logic             bl8,
   input  logic [T_W-1:0]   twtr,
   input  logic [T_W-1:0]   twr,
   input  logic [T_W-1:0]   trp,
   output logic [CNT_W-1:0] rd_gap,
   output logic [CNT_W-1:0] pre_gap,
   output logic [CNT_W-1:0] act_gap
);

   localparam int NEED_W = ((LAT_W > T_W) ? LAT_W : T_W) + 2;

   if (CNT_W < NEED_W) begin : g_bad_width
      $error("twg_lat_calc: CNT_W too narrow for the configured latency widths");
   end

   logic [CNT_W-1:0] al_w, cl_w, cl_m1, half_burst, rl, wl;

   always_comb begin
      al_w       = CNT_W'(al);
      cl_w       = CNT_W'(cl);
      cl_m1      = (cl_w == '0) ? '0 : cl_w - CNT_W'(1);
      half_burst = bl8 ? CNT_W'(4) : CNT_W'(2);
      rl         = al_w + cl_w;
      wl         = (rl == '0) ? '0 : rl - CNT_W'(1);
      rd_gap     = cl_m1 + half_burst + CNT_W'(twtr);
      pre_gap    = wl + half_burst + CNT_W'(twr);
      act_gap    = CNT_W'(trp);
   end

endmodule

// File: rtl/twg_dncnt.sv
// Spacing timer: loaded with a gap g on the issuing cycle, reports clear g cycles later.
module twg_dncnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] gap,
   output logic             clear
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("twg_dncnt: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (load) begin
         remain <= (gap == '0) ? '0 : gap - CNT_W'(1);
      end else if (remain != '0) begin
         remain <= remain - CNT_W'(1);
      end
   end

   assign clear = (remain == '0);

   // R2: a load with a gap above one keeps the timer busy in the next cycle
   a_r2_load_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (load && gap > CNT_W'(1)) |=> !clear);

   // R1: once clear and not reloaded, the timer stays clear
   a_r1_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !load) |=> clear);

endmodule

// File: rtl/twg_gate.sv
module twg_gate #(
   parameter int NBANK       = 4,
   parameter int LAT_W       = 3,
   parameter int T_W         = 4,
   parameter bit PER_BANK_WR = 1'b1,
   localparam int BANK_W     = (NBANK > 1) ? $clog2(NBANK) : 1,
   localparam int CNT_W      = LAT_W + T_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LAT_W-1:0]  cfg_al,
   input  logic [LAT_W-1:0]  cfg_cl,
   input  logic              cfg_bl8,
   input  logic [T_W-1:0]    cfg_twtr,
   input  logic [T_W-1:0]    cfg_twr,
   input  logic [T_W-1:0]    cfg_trp,
   input  logic              req_valid,
   input  logic [2:0]        req_cmd,
   input  logic [BANK_W-1:0] req_bank,
   output logic              req_ready,
   output logic [1:0]        hold_why
);
   import twg_pkg::*;

   if (NBANK < 2 || (NBANK & (NBANK - 1)) != 0) begin : g_bad_nbank
      $error("twg_gate: NBANK must be a power of two, at least 2");
   end
   if (LAT_W < 2 || T_W < 2) begin : g_bad_lat
      $error("twg_gate: LAT_W and T_W must be at least 2");
   end

   twg_cmd_e         cmd;
   logic [CNT_W-1:0] rd_gap, pre_gap, act_gap;
   logic             grant, wr_go, pre_go;
   logic             wtr_clear;
   logic [NBANK-1:0] wr_clear, rp_clear;
   logic             allowed;
   twg_hold_e        why;
   logic             started;

   assign cmd    = twg_cmd_e'(req_cmd);
   assign grant  = req_valid && req_ready;
   assign wr_go  = grant && (cmd == CMD_WR);
   assign pre_go = grant && (cmd == CMD_PRE);

   twg_lat_calc #(.LAT_W(LAT_W), .T_W(T_W), .CNT_W(CNT_W)) u_lat (
      .al(cfg_al), .cl(cfg_cl), .bl8(cfg_bl8),
      .twtr(cfg_twtr), .twr(cfg_twr), .trp(cfg_trp),
      .rd_gap(rd_gap), .pre_gap(pre_gap), .act_gap(act_gap)
   );

   // Write-to-read turnaround applies to every bank: one shared timer.
   twg_dncnt #(.CNT_W(CNT_W)) u_wtr (
      .clk(clk), .rst_n(rst_n), .load(wr_go), .gap(rd_gap), .clear(wtr_clear)
   );

   // Write recovery: one timer per bank, or one conservative shared timer.
   if (PER_BANK_WR) begin : g_wr_bank
      for (genvar b = 0; b < NBANK; b++) begin : g_b
         logic hit;
         assign hit = wr_go && (req_bank == BANK_W'(b));
         twg_dncnt #(.CNT_W(CNT_W)) u_wr (
            .clk(clk), .rst_n(rst_n), .load(hit), .gap(pre_gap), .clear(wr_clear[b])
         );
      end
   end else begin : g_wr_shared
      logic shared_clear;
      twg_dncnt #(.CNT_W(CNT_W)) u_wr (
         .clk(clk), .rst_n(rst_n), .load(wr_go), .gap(pre_gap), .clear(shared_clear)
      );
      assign wr_clear = {NBANK{shared_clear}};
   end

   // Row precharge: always tracked per bank.
   for (genvar b = 0; b < NBANK; b++) begin : g_rp
      logic hit;
      assign hit = pre_go && (req_bank == BANK_W'(b));
      twg_dncnt #(.CNT_W(CNT_W)) u_rp (
         .clk(clk), .rst_n(rst_n), .load(hit), .gap(act_gap), .clear(rp_clear[b])
      );
   end

   always_comb begin
      allowed = 1'b1;
      why     = HOLD_NONE;
      unique case (cmd)
         CMD_RD: begin
            allowed = wtr_clear;
            why     = HOLD_WTR;
         end
         CMD_PRE: begin
            allowed = wr_clear[req_bank];
            why     = HOLD_WR;
         end
         CMD_ACT: begin
            allowed = rp_clear[req_bank];
            why     = HOLD_RP;
         end
         default: begin
            allowed = 1'b1;
            why     = HOLD_NONE;
         end
      endcase
   end

   assign req_ready = allowed;
   assign hold_why  = (req_valid && !allowed) ? why : HOLD_NONE;

   always_ff @(posedge clk) begin
      if (!rst_n) started <= 1'b0;
      else        started <= 1'b1;
   end

   // R7: NOP and WRITE are never held
   a_r7_nop_wr_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (cmd == CMD_NOP || cmd == CMD_WR)) |-> req_ready);

   // R3: a READ can never issue in the cycle right after a WRITE
   a_r3_rd_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $past(wr_go) && req_valid && cmd == CMD_RD) |-> !req_ready);

   // R4: a same-bank PRECHARGE can never issue right after a WRITE
   a_r4_pre_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $past(wr_go) && req_valid && cmd == CMD_PRE
       && req_bank == $past(req_bank)) |-> !req_ready);

   // R6: ACTIVATE held right after a same-bank PRECHARGE when tRP exceeds one
   a_r6_act_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $past(pre_go) && req_valid && cmd == CMD_ACT
       && req_bank == $past(req_bank) && cfg_trp > T_W'(1)) |-> !req_ready);

   // R10: a reason is given exactly for held valid requests
   a_r10_reason: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |-> (hold_why != HOLD_NONE));
   a_r10_no_reason: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready || !req_valid) |-> (hold_why == HOLD_NONE));

endmodule

// File: tb/tb_twg_gate.sv
module tb_twg_gate;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cfg_al = 3'd0, cfg_cl = 3'd3;
   logic       cfg_bl8 = 1'b0;
   logic [3:0] cfg_twtr = 4'd2, cfg_twr = 4'd2, cfg_trp = 4'd3;
   logic       req_valid = 1'b0;
   logic [2:0] req_cmd = 3'd0;
   logic [1:0] req_bank = 2'd0;
   logic       req_ready;
   logic [1:0] hold_why;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;   // 125 MHz

   twg_gate dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_bl8(cfg_bl8),
      .cfg_twtr(cfg_twtr), .cfg_twr(cfg_twr), .cfg_trp(cfg_trp),
      .req_valid(req_valid), .req_cmd(req_cmd), .req_bank(req_bank),
      .req_ready(req_ready), .hold_why(hold_why)
   );

   localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, WR = 3'd2, RD = 3'd3, PRE = 3'd4;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Offer a command in the next cycle and let it issue at the edge.
   task automatic issue(input logic [2:0] c, input logic [1:0] b);
      @(negedge clk);
      req_valid = 1'b1; req_cmd = c; req_bank = b;
      @(posedge clk);
      #1 req_valid = 1'b0; req_cmd = NOP;
   endtask

   // Right after an issue: offer c to b each cycle until ready, return the gap in cycles.
   task automatic probe(input logic [2:0] c, input logic [1:0] b, input int exp,
                        input int reason, input string tag);
      int got = 0;
      for (int k = 1; k <= 60; k++) begin
         @(negedge clk);
         req_valid = 1'b1; req_cmd = c; req_bank = b;
         #2;
         if (k == exp - 1)
            chk(!req_ready && hold_why == 2'(reason), {tag, " early hold"},
                int'(hold_why), reason);
         if (req_ready) begin
            got = k;
            break;
         end
      end
      @(posedge clk);
      #1 req_valid = 1'b0; req_cmd = NOP;
      chk(got == exp, {tag, " earliest gap"}, got, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   // Offer without issuing; check ready and reason at once.
   task automatic peek(input logic [2:0] c, input logic [1:0] b, input bit exp_rdy,
                       input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_cmd = c; req_bank = b;
      #2;
      chk(req_ready == exp_rdy && (exp_rdy ? hold_why == 2'd0 : hold_why != 2'd0),
          tag, int'(req_ready), int'(exp_rdy));
      req_valid = 1'b0; req_cmd = NOP;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int half, rd_exp, pre_exp;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: nothing pending after reset
      peek(RD, 2'd1, 1'b1, "R1 read after reset");
      peek(PRE, 2'd2, 1'b1, "R1 precharge after reset");
      peek(ACT, 2'd3, 1'b1, "R1 activate after reset");
      // R10: no reason when not valid
      @(negedge clk); req_valid = 1'b0; req_cmd = RD; #2;
      chk(hold_why == 2'd0, "R10 idle reason", int'(hold_why), 0);
      req_cmd = NOP;

      for (int al = 0; al <= 2; al++)
         for (int cl = 3; cl <= 4; cl++)
            for (int bl = 0; bl <= 1; bl++)
               for (int tw = 1; tw <= 2; tw++)
                  for (int tr = 2; tr <= 3; tr++) begin
                     cfg_al = 3'(al); cfg_cl = 3'(cl); cfg_bl8 = 1'(bl);
                     cfg_twtr = 4'(tw); cfg_twr = 4'(tr);
                     half = bl ? 4 : 2;                      // R8
                     rd_exp = (cl - 1) + half + tw;
                     pre_exp = (al + cl - 1) + half + tr;
                     idle(2);
                     // R2, R3: read to a different bank than the write
                     issue(WR, 2'd0);
                     probe(RD, 2'd3, rd_exp, 1, "R2 R3 R8 read spacing");
                     idle(20);
                     // R4: precharge to the written bank
                     issue(WR, 2'd1);
                     probe(PRE, 2'd1, pre_exp, 2, "R4 R8 precharge spacing");
                     idle(20);
                     // R7, R5: NOP/WRITE after a write, precharge of other bank
                     issue(WR, 2'd2);
                     peek(NOP, 2'd2, 1'b1, "R7 nop after write");
                     issue(WR, 2'd2);
                     peek(PRE, 2'd0, 1'b1, "R5 other-bank precharge");
                     idle(20);
                     // R9: second write restarts spacing
                     issue(WR, 2'd0);
                     idle(1);
                     issue(WR, 2'd3);
                     probe(RD, 2'd0, rd_exp, 1, "R9 restart");
                     idle(20);
                  end

      // R6: precharge-to-activate spacing
      cfg_al = 3'd0; cfg_cl = 3'd3; cfg_bl8 = 1'b0; cfg_twtr = 4'd2; cfg_twr = 4'd2;
      for (int rp = 2; rp <= 5; rp++) begin
         cfg_trp = 4'(rp);
         idle(2);
         issue(PRE, 2'd2);
         peek(ACT, 2'd3, 1'b1, "R6 other-bank activate");
         idle(20);
         issue(PRE, 2'd1);
         probe(ACT, 2'd1, rp, 3, "R6 activate spacing");
         idle(20);
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule